// File: doc/BRIEF.md
# Three-Lane Seven-to-One Serial Receiver

This block turns three serial data lanes back into a 21-bit parallel word. A forwarded frame clock travels with the lanes, and each lane carries seven bits in every frame-clock period. The design runs from a free sampling clock at seven times the frame rate. It finds each rising edge of the sampled frame clock, captures one bit per lane on each sampling tick, and stores the assembled word in a staging register. At the end of the next frame the word moves to the parallel outputs. A regenerated output clock marks those outputs, and its rising edge falls in the middle of the stable data.

An active-low power-down input clears the outputs. After power-down or reset, a settle interval counted in frame-clock edges stands in for oscillator lock. Fail-safe behaviour covers lines that go quiet. A lane flagged idle reads as ones. If the frame clock stops, the outputs keep the last word and the output clock stays low.

Top module: `rx7_deser`

## Requirements
- R1: Bit j of a frame on lane l lands on `par_out[7*l + j]`. Bit 0 is the sample taken at the first sampling edge that sees the frame clock high after it was low, and the next six bits follow on consecutive sampling edges.
- R2: The word of frame n appears on `par_out` at the sampling edge that captures bit 6 of frame n+1. It is not visible before that edge.
- R3: When frames are seven sampling cycles long, `out_clk` is high for four consecutive cycles and low for three, with the high part in the second half of the frame. `par_out` changes only while `out_clk` is low, and it is stable when `out_clk` rises.
- R4: While `pd_n` is low, `par_out` is all zero and `out_clk` is low from the next sampling edge on, whatever the idle flags are. Power-down takes priority over every fail-safe rule.
- R5: After reset or the release of `pd_n`, the first LOCK_FRAMES (default 64) frame-clock rising edges form a settle interval, during which `par_out` is zero and `out_clk` is low. The frame that starts at the last of these edges is the first word delivered. It appears at the end of the frame that follows it.
- R6: When `lane_idle[l]` is high while the frame clock runs, the seven bits of lane l in that frame read as 1, and the other lanes are unaffected.
- R7: If the frame clock shows no rising edge for 16 sampling cycles, `out_clk` stays low and `par_out` keeps the last delivered word. The word waiting in staging is dropped, so after the clock returns the first new word appears at the end of the second frame.
- R8: Every frame-clock rising edge restarts capture at bit 0. A frame cut short before its seventh bit produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, seven times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| fclk_in | input | 1 | Forwarded frame clock, as sampled |
| lane_in | input | 3 | Serial data, one bit per lane |
| lane_idle | input | 3 | Per-lane fail-safe idle indication |
| par_out | output | 21 | Recovered parallel word |
| out_clk | output | 1 | Regenerated output clock; its rising edge strobes `par_out` |

## Verification
The vector walk sends words with one lane set and the others clear, alternating and walking patterns, all ones, and frames with one, two or all three lanes idle. These patterns distinguish a swapped lane, a reversed bit order and an idle flag that leaks into a neighbouring lane. A sample one cycle before the capture of the last bit pins down the exact cycle of the two-frame latency. Directed sequences cover the full settle count after reset and after power-down, with an off-by-one frame boundary visible. They also cover a truncated frame, which must leave no word behind, a stopped frame clock, which must drop the staged word and hold the outputs, and power-down applied together with idle lanes.

// File: rtl/rx7_pkg.sv
package rx7_pkg;
    localparam int unsigned DEF_LANES = 3;
    localparam int unsigned DEF_BITS  = 7;
    localparam int unsigned DEF_LOSS  = 16;
    localparam int unsigned DEF_LOCK  = 64;

    // first phase of the frame at which the output clock is high
    function automatic int unsigned clk_hi_first(input int unsigned bits);
        return bits - (bits + 1) / 2;
    endfunction
endpackage

// File: rtl/rx7_frame_track.sv
module rx7_frame_track #(
    parameter int unsigned BITS     = 7,
    parameter int unsigned LOSS_CYC = 16,
    parameter int unsigned PW       = $clog2(BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fclk_in,
    output logic          rise,
    output logic          cap,
    output logic [PW-1:0] cap_idx,
    output logic          done,
    output logic          lost,
    output logic [PW-1:0] ph_next
);
    localparam int unsigned CW = $clog2(LOSS_CYC + 1);
    localparam logic [PW-1:0] IDLE_PH = PW'(BITS);

    typedef struct packed {
        logic          fprev;
        logic [PW-1:0] phase;
        logic [CW-1:0] gap;
        logic          lost;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d       = trk_q;
        trk_d.fprev = fclk_in;
        rise        = fclk_in & ~trk_q.fprev;
        cap         = 1'b0;
        cap_idx     = '0;
        if (rise) begin
            cap         = 1'b1;
            trk_d.phase = PW'(1);
            trk_d.gap   = '0;
            trk_d.lost  = 1'b0;
        end else begin
            if (trk_q.gap != CW'(LOSS_CYC)) begin
                trk_d.gap = trk_q.gap + 1'b1;
            end
            trk_d.lost = (trk_d.gap == CW'(LOSS_CYC));
            if (trk_q.lost || trk_d.lost) begin
                trk_d.phase = IDLE_PH;
            end else if (trk_q.phase < IDLE_PH) begin
                cap         = 1'b1;
                cap_idx     = trk_q.phase;
                trk_d.phase = trk_q.phase + 1'b1;
            end
        end
        done    = cap && (cap_idx == PW'(BITS - 1));
        lost    = trk_q.lost;
        ph_next = trk_d.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{fprev: 1'b0, phase: IDLE_PH, gap: '0, lost: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    // R8
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (trk_q.phase == PW'(1) && !trk_q.lost));
endmodule

// File: rtl/rx7_lane_shift.sv
module rx7_lane_shift #(
    parameter int unsigned BITS = 7,
    parameter int unsigned PW   = $clog2(BITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_in,
    input  logic            idle,
    input  logic            cap,
    input  logic [PW-1:0]   cap_idx,
    output logic [BITS-1:0] word_next
);
    typedef struct packed {
        logic [BITS-1:0] bits;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (cap) begin
            lane_d.bits[cap_idx] = bit_in | idle;
        end
        word_next = lane_d.bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end
endmodule

// File: rtl/rx7_lock_timer.sv
module rx7_lock_timer #(
    parameter int unsigned LOCK_FRAMES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic rise,
    output logic locked
);
    localparam int unsigned CW = $clog2(LOCK_FRAMES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          locked;
    } lck_t;

    lck_t lck_d, lck_q;

    always_comb begin
        lck_d = lck_q;
        if (!pd_n) begin
            lck_d = '0;
        end else if (!lck_q.locked && rise) begin
            lck_d.cnt = lck_q.cnt + 1'b1;
            if (lck_d.cnt == CW'(LOCK_FRAMES)) begin
                lck_d.locked = 1'b1;
            end
        end
        locked = lck_q.locked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lck_q <= '0;
        end else begin
            lck_q <= lck_d;
        end
    end

    // R5
    settle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lck_q.locked && pd_n) |=> lck_q.locked);
endmodule

// File: rtl/rx7_deser.sv
module rx7_deser #(
    parameter int unsigned LANES       = rx7_pkg::DEF_LANES,
    parameter int unsigned BITS        = rx7_pkg::DEF_BITS,
    parameter int unsigned LOSS_CYC    = rx7_pkg::DEF_LOSS,
    parameter int unsigned LOCK_FRAMES = rx7_pkg::DEF_LOCK
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pd_n,
    input  logic                  fclk_in,
    input  logic [LANES-1:0]      lane_in,
    input  logic [LANES-1:0]      lane_idle,
    output logic [LANES*BITS-1:0] par_out,
    output logic                  out_clk
);
    localparam int unsigned W  = LANES * BITS;
    localparam int unsigned PW = $clog2(BITS + 1);
    localparam logic [PW-1:0] HI_FIRST = PW'(rx7_pkg::clk_hi_first(BITS));
    localparam logic [PW-1:0] HI_END   = PW'(BITS);

    logic          rise, cap, done, lost, locked;
    logic [PW-1:0] cap_idx, ph_next;
    logic [W-1:0]  asm_word;

    rx7_frame_track #(.BITS(BITS), .LOSS_CYC(LOSS_CYC), .PW(PW)) i_track (
        .clk(clk), .rst_n(rst_n), .fclk_in(fclk_in),
        .rise(rise), .cap(cap), .cap_idx(cap_idx), .done(done),
        .lost(lost), .ph_next(ph_next)
    );

    rx7_lock_timer #(.LOCK_FRAMES(LOCK_FRAMES)) i_lock (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .rise(rise), .locked(locked)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rx7_lane_shift #(.BITS(BITS), .PW(PW)) i_lane (
            .clk(clk), .rst_n(rst_n),
            .bit_in(lane_in[g]), .idle(lane_idle[g]),
            .cap(cap), .cap_idx(cap_idx),
            .word_next(asm_word[g*BITS +: BITS])
        );
    end

    typedef struct packed {
        logic [W-1:0] stage;
        logic         stage_vld;
        logic [W-1:0] dout;
        logic         dout_vld;
        logic         oclk;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (!pd_n || !locked) begin
            out_d.dout      = '0;
            out_d.dout_vld  = 1'b0;
            out_d.stage_vld = 1'b0;
            out_d.oclk      = 1'b0;
        end else begin
            if (lost) begin
                out_d.stage_vld = 1'b0;
            end
            if (done) begin
                out_d.stage     = asm_word;
                out_d.stage_vld = 1'b1;
                if (out_q.stage_vld) begin
                    out_d.dout     = out_q.stage;
                    out_d.dout_vld = 1'b1;
                end
            end
            out_d.oclk = out_d.dout_vld && (ph_next >= HI_FIRST) && (ph_next < HI_END);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign par_out = out_q.dout;
    assign out_clk = out_q.oclk;

    // R4
    pd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (par_out == '0 && !out_clk));

    // R5
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> (par_out == '0 && !out_clk));

    // R3
    data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_out != $past(par_out)) |-> !out_clk);

    // R3
    strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_clk) |-> $stable(par_out));

    // R7
    loss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && pd_n && locked) |=> $stable(par_out));
endmodule

// File: tb/test_rx7_deser.sv
module test_rx7_deser;
    localparam int unsigned LOCK = 64;
    localparam int unsigned NV   = 8;

    localparam logic [20:0] VEC_W [NV] = '{
        21'h00007F, 21'h1FC000, 21'h0AAAAA, 21'h155555,
        21'h000001, 21'h003F80, 21'h1FFFFF, 21'h123456
    };
    localparam logic [2:0] VEC_I [NV] = '{
        3'b000, 3'b000, 3'b001, 3'b000, 3'b110, 3'b000, 3'b111, 3'b010
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_n = 1'b1;
    logic        fclk_in = 1'b0;
    logic [2:0]  lane_in = '0;
    logic [2:0]  lane_idle = '0;
    logic [20:0] par_out;
    logic        out_clk;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    logic [20:0] seen;
    logic [20:0] pre6;
    int          hi_cnt;

    rx7_deser #(.LOCK_FRAMES(LOCK)) i_rx7_deser (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .fclk_in(fclk_in),
        .lane_in(lane_in), .lane_idle(lane_idle),
        .par_out(par_out), .out_clk(out_clk)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [20:0] expect_word(input logic [20:0] w, input logic [2:0] idl);
        logic [20:0] r = w;
        for (int l = 0; l < 3; l++) begin
            if (idl[l]) r[l*7 +: 7] = 7'h7F;
        end
        return r;
    endfunction

    // one frame of nslots sampling cycles; frame clock high in slots 0..3
    task automatic send(input logic [20:0] w, input int nslots);
        hi_cnt = 0;
        for (int j = 0; j < nslots; j++) begin
            @(negedge clk);
            if (out_clk) hi_cnt++;
            if (j == 6) pre6 = par_out;
            fclk_in = (j < 4);
            for (int l = 0; l < 3; l++) lane_in[l] = w[l*7 + j];
        end
        @(posedge clk);
        #1;
        seen = par_out;
    endtask

    task automatic pause(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            fclk_in = 1'b0;
            lane_in = 3'b101;
        end
        @(posedge clk);
        #1;
    endtask

    function automatic logic [20:0] lk_word(input logic [20:0] base, input int k);
        return base ^ (21'(k) << 3);
    endfunction

    task automatic settle_run(input logic [20:0] base);
        for (int k = 1; k <= LOCK; k++) begin
            send(lk_word(base, k), 7);
            chk(seen == '0 && hi_cnt == 0, "R5 settle quiet", {11'b0, seen}, 32'h0);
        end
        send(lk_word(base, LOCK + 1), 7);
        chk(seen == lk_word(base, LOCK), "R5 first word", {11'b0, seen}, {11'b0, lk_word(base, LOCK)});
        chk(hi_cnt == 0, "R5 clock low before first word", hi_cnt, 0);
        send(lk_word(base, LOCK + 2), 7);
        chk(seen == lk_word(base, LOCK + 1), "R2 second word", {11'b0, seen}, {11'b0, lk_word(base, LOCK + 1)});
        chk(hi_cnt == 4, "R3 clock high cycles", hi_cnt, 4);
    endtask

    initial begin
        #(8 * 200000);
        if (!ended) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5 reset state
        chk(par_out == '0 && !out_clk, "R5 reset state", {10'b0, out_clk, par_out}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        settle_run(21'h1A5000);

        // vector walk: R1 mapping, R6 idle lanes, R2 latency, R3 clock shape
        lane_idle = VEC_I[0];
        send(VEC_W[0], 7);
        for (int i = 1; i < NV; i++) begin
            lane_idle = VEC_I[i];
            send(VEC_W[i], 7);
            chk(seen == expect_word(VEC_W[i-1], VEC_I[i-1]),
                (VEC_I[i-1] != 0) ? "R6 idle lane word" : "R1 lane mapping",
                {11'b0, seen}, {11'b0, expect_word(VEC_W[i-1], VEC_I[i-1])});
            chk(hi_cnt == 4, "R3 clock high cycles", hi_cnt, 4);
            if (i >= 2) begin
                chk(pre6 == expect_word(VEC_W[i-2], VEC_I[i-2]), "R2 no early update",
                    {11'b0, pre6}, {11'b0, expect_word(VEC_W[i-2], VEC_I[i-2])});
            end
        end
        lane_idle = '0;

        // R8: truncated frame leaves no word
        send(21'h1FFFFF, 5);
        send(21'h0F0F0F, 7);
        chk(seen == expect_word(VEC_W[NV-1], VEC_I[NV-1]), "R8 truncated frame dropped",
            {11'b0, seen}, {11'b0, expect_word(VEC_W[NV-1], VEC_I[NV-1])});
        send(21'h10E1E1, 7);
        chk(seen == 21'h0F0F0F, "R8 realigned word", {11'b0, seen}, 32'h0F0F0F);

        // R7: frame clock stops
        pause(30);
        chk(par_out == 21'h0F0F0F, "R7 hold during loss", {11'b0, par_out}, 32'h0F0F0F);
        chk(!out_clk, "R7 clock low during loss", {31'b0, out_clk}, 32'h0);
        send(21'h0C3C3C, 7);
        chk(seen == 21'h0F0F0F, "R7 staged word dropped", {11'b0, seen}, 32'h0F0F0F);
        send(21'h033333, 7);
        chk(seen == 21'h0C3C3C, "R7 resume word", {11'b0, seen}, 32'h0C3C3C);

        // R4: power-down with idle lanes
        pd_n = 1'b0;
        lane_idle = 3'b111;
        send(21'h155555, 7);
        chk(seen == '0, "R4 outputs low", {11'b0, seen}, 32'h0);
        chk(hi_cnt == 0, "R4 clock low", hi_cnt, 0);
        send(21'h0AAAAA, 7);
        chk(seen == '0 && !out_clk, "R4 priority over idle", {10'b0, out_clk, seen}, 32'h0);
        pd_n = 1'b1;
        lane_idle = '0;

        settle_run(21'h0B7000);

        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule